// File: doc/BRIEF.md
# Dual-Threshold Fault Latch

This block turns one analog fault pin, seen through two comparators, into a latched shutdown decision for a power controller. One comparator reports the pin above its upper (overvoltage) threshold. The other reports the pin below its lower (overtemperature) threshold. Either condition shuts the controller down and keeps it down.

Each comparator output passes through its own stability filter before the block acts on it. The pull-up current source used for the low-threshold measurement is enabled only after the supply reports it is ready. While soft-start runs, the low-threshold result is masked so that the pin's bypass capacitor can charge. Once tripped, the block holds its off state and its cause code until a latch-reset input clears them. If both causes arrive together, overvoltage wins. After that, the first cause recorded is kept.

Top module: `fault_guard`

## Requirements
- R1: After reset, `latched_off` is 0, `cause` is 2'b00 and `bias_en` is 0.
- R2: A high `ovp_cmp` sampled on STABLE_CYC consecutive clock edges sets `latched_off` to 1 and `cause` to 2'b01 (overvoltage). Both are visible after the next edge, STABLE_CYC+1 edges after the first high sample.
- R3: A comparator pulse lasting fewer than STABLE_CYC consecutive edges is never accepted, and `latched_off` stays 0.
- R4: With `bias_en` at 1 and `softstart_act` at 0, a high `otp_cmp` held for STABLE_CYC edges sets `latched_off` to 1 and `cause` to 2'b10 (overtemperature), with the same latency as R2.
- R5: While `softstart_act` is 1, an accepted `otp_cmp` has no effect on `latched_off` or `cause`.
- R6: `bias_en` equals `supply_ok` as sampled on the previous edge. While `bias_en` is 0, an accepted `otp_cmp` has no effect.
- R7: Once latched, `cause` keeps its first value even if the other comparator later becomes active.
- R8: If both faults are accepted on the same edge, `cause` becomes 2'b01.
- R9: Once latched, `latched_off` stays 1 after both comparators return low, until `latch_clr` is sampled high. One edge after that, `latched_off` is 0 and `cause` is 2'b00.
- R10: While `latch_clr` is high, no fault is latched. A fault that is still accepted when `latch_clr` falls latches on the next edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| ovp_cmp | input | 1 | Pin above upper threshold |
| otp_cmp | input | 1 | Pin below lower threshold |
| supply_ok | input | 1 | Supply has reached its turn-on level |
| softstart_act | input | 1 | Soft-start in progress |
| latch_clr | input | 1 | Clears the latched state |
| latched_off | output | 1 | Controller latched off |
| cause | output | 2 | 00 none, 01 overvoltage, 10 overtemperature |
| bias_en | output | 1 | Enable for the pin pull-up current source |

## Verification
The latch outputs are due STABLE_CYC+1 edges after the first edge that samples a comparator high. `bias_en` is due one edge after `supply_ok` changes, and a clear takes effect one edge after `latch_clr` is sampled. The driver records each expected result together with the cycle number in which it is due. The monitor samples on falling edges and compares each result only in that exact cycle. It also checks the cycle just before a trip is due, so a result that arrives early or late is caught.

// File: rtl/fg_pkg.sv
package fg_pkg;
  typedef enum logic [1:0] {
    CAUSE_NONE = 2'b00,
    CAUSE_OVER = 2'b01,
    CAUSE_TEMP = 2'b10
  } cause_e;

  localparam int CH_OVER = 0;
  localparam int CH_TEMP = 1;
  localparam int N_CH    = 2;

  // Priority pick: overvoltage dominates when both are present.
  function automatic cause_e pick_cause(input logic over, input logic temp);
    if (over)      return CAUSE_OVER;
    else if (temp) return CAUSE_TEMP;
    else           return CAUSE_NONE;
  endfunction
endpackage

// File: rtl/fg_debounce.sv
module fg_debounce #(
  parameter int STABLE_CYC = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic raw,
  output logic filt
);
  localparam int CW = (STABLE_CYC < 2) ? 1 : $clog2(STABLE_CYC + 1);
  localparam logic [CW-1:0] LAST = CW'(STABLE_CYC - 1);

  logic [CW-1:0] cnt;
  logic          differs;
  logic          accept;

  function automatic logic [CW-1:0] bump(input logic [CW-1:0] c);
    return c + CW'(1);
  endfunction

  assign differs = (raw != filt);
  assign accept  = differs && (cnt == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt  <= '0;
      filt <= 1'b0;
    end else if (accept) begin
      cnt  <= '0;
      filt <= raw;
    end else if (differs) begin
      cnt  <= bump(cnt);
    end else begin
      cnt  <= '0;
    end
  end

  // R3: the filtered value only moves to a level the raw input held at the last edge
  a_r3_follow_raw: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(filt) |-> ($past(raw) == filt));
  a_r3_cnt_bound: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= LAST);
endmodule

// File: rtl/fg_qualify.sv
module fg_qualify (
  input  logic clk,
  input  logic rst_n,
  input  logic supply_ok,
  input  logic softstart_act,
  input  logic over_acc,
  input  logic temp_acc,
  output logic bias_en,
  output logic over_q,
  output logic temp_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) bias_en <= 1'b0;
    else        bias_en <= supply_ok;
  end

  assign over_q = over_acc;
  assign temp_q = temp_acc && bias_en && !softstart_act;

  // R6: bias source follows the supply flag one edge later
  a_r6_bias_on: assert property (@(posedge clk) disable iff (!rst_n)
    supply_ok |=> bias_en);
  a_r6_bias_off: assert property (@(posedge clk) disable iff (!rst_n)
    !supply_ok |=> !bias_en);
endmodule

// File: rtl/fg_latch.sv
module fg_latch
  import fg_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   over_q,
  input  logic   temp_q,
  input  logic   latch_clr,
  output logic   latched_off,
  output cause_e cause
);
  logic   trip;
  cause_e next_cause;

  assign next_cause = pick_cause(over_q, temp_q);
  assign trip       = !latched_off && !latch_clr && (next_cause != CAUSE_NONE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      latched_off <= 1'b0;
      cause       <= CAUSE_NONE;
    end else if (latch_clr) begin
      latched_off <= 1'b0;
      cause       <= CAUSE_NONE;
    end else if (trip) begin
      latched_off <= 1'b1;
      cause       <= next_cause;
    end
  end

  // R9: latched state persists until cleared
  a_r9_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (latched_off && !latch_clr) |=> latched_off);
  // R9: clear empties the latch one edge later
  a_r9_clear: assert property (@(posedge clk) disable iff (!rst_n)
    latch_clr |=> (!latched_off && cause == CAUSE_NONE));
  // R7: cause frozen while latched
  a_r7_cause_kept: assert property (@(posedge clk) disable iff (!rst_n)
    (latched_off && !latch_clr) |=> $stable(cause));
  // R2: a latched state always carries a real cause
  a_r2_code_valid: assert property (@(posedge clk) disable iff (!rst_n)
    latched_off |-> (cause == CAUSE_OVER || cause == CAUSE_TEMP));
  // R8: overvoltage dominates a simultaneous trip
  a_r8_priority: assert property (@(posedge clk) disable iff (!rst_n)
    (!latched_off && !latch_clr && over_q) |=> (cause == CAUSE_OVER));
endmodule

// File: rtl/fault_guard.sv
module fault_guard
  import fg_pkg::*;
#(
  parameter int STABLE_CYC = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       ovp_cmp,
  input  logic       otp_cmp,
  input  logic       supply_ok,
  input  logic       softstart_act,
  input  logic       latch_clr,
  output logic       latched_off,
  output logic [1:0] cause,
  output logic       bias_en
);
  logic [N_CH-1:0] raw_vec;
  logic [N_CH-1:0] acc_vec;
  logic            over_q;
  logic            temp_q;
  cause_e          cause_int;

  assign raw_vec[CH_OVER] = ovp_cmp;
  assign raw_vec[CH_TEMP] = otp_cmp;

  for (genvar g = 0; g < N_CH; g++) begin : g_filt
    fg_debounce #(.STABLE_CYC(STABLE_CYC)) i_deb (
      .clk  (clk),
      .rst_n(rst_n),
      .raw  (raw_vec[g]),
      .filt (acc_vec[g])
    );
  end

  fg_qualify i_qual (
    .clk          (clk),
    .rst_n        (rst_n),
    .supply_ok    (supply_ok),
    .softstart_act(softstart_act),
    .over_acc     (acc_vec[CH_OVER]),
    .temp_acc     (acc_vec[CH_TEMP]),
    .bias_en      (bias_en),
    .over_q       (over_q),
    .temp_q       (temp_q)
  );

  fg_latch i_latch (
    .clk        (clk),
    .rst_n      (rst_n),
    .over_q     (over_q),
    .temp_q     (temp_q),
    .latch_clr  (latch_clr),
    .latched_off(latched_off),
    .cause      (cause_int)
  );

  assign cause = cause_int;

  // R5: temperature fault masked during soft-start
  a_r5_softstart_mask: assert property (@(posedge clk) disable iff (!rst_n)
    (!latched_off && softstart_act && !acc_vec[CH_OVER]) |=> !latched_off);
  // R10: clear input dominates any trip
  a_r10_clear_wins: assert property (@(posedge clk) disable iff (!rst_n)
    latch_clr |=> !latched_off);
endmodule

// File: tb/test_fault_guard.sv
module test_fault_guard;
  localparam int S = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ovp_cmp = 1'b0, otp_cmp = 1'b0, supply_ok = 1'b0;
  logic softstart_act = 1'b0, latch_clr = 1'b0;
  logic latched_off, bias_en;
  logic [1:0] cause;

  int checks = 0;
  int errors = 0;
  int cyc = 0;

  typedef struct {
    int         due;
    logic       lo;
    logic [1:0] cs;
    logic       be;
    string      tag;
  } exp_t;
  exp_t q[$];

  always #2 clk = ~clk;  // 250 MHz

  fault_guard #(.STABLE_CYC(S)) i_fault_guard (
    .clk(clk), .rst_n(rst_n), .ovp_cmp(ovp_cmp), .otp_cmp(otp_cmp),
    .supply_ok(supply_ok), .softstart_act(softstart_act), .latch_clr(latch_clr),
    .latched_off(latched_off), .cause(cause), .bias_en(bias_en)
  );

  // Latency of a trip counted from the drive cycle: S filter samples, one latch edge.
  function automatic int trip_lat(int stable);
    return stable + 1;
  endfunction

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc == 20000) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=hung expected=done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  // Monitor: compare expected items in the cycle they are due
  always @(negedge clk) begin
    while (q.size() > 0 && q[0].due <= cyc) begin
      exp_t e;
      e = q.pop_front();
      checks++;
      if (e.due != cyc || latched_off !== e.lo || cause !== e.cs || bias_en !== e.be) begin
        errors++;
        $display("FAIL %s @%0d: actual lo=%b cause=%b bias=%b expected lo=%b cause=%b bias=%b",
                 e.tag, cyc, latched_off, cause, bias_en, e.lo, e.cs, e.be);
      end
    end
  end

  task automatic push(int dly, logic lo, logic [1:0] cs, logic be, string tag);
    exp_t e;
    e.due = cyc + dly; e.lo = lo; e.cs = cs; e.be = be; e.tag = tag;
    q.push_back(e);
  endtask

  task automatic tick(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic drain();
    while (q.size() > 0) @(negedge clk);
  endtask

  initial begin
    tick(3);
    rst_n = 1'b1;
    push(1, 1'b0, 2'b00, 1'b0, "R1 reset state");
    drain();

    // R6: bias follows supply one edge later
    supply_ok = 1'b1;
    push(1, 1'b0, 2'b00, 1'b1, "R6 bias on");
    drain();

    // R3: short overvoltage pulse rejected
    ovp_cmp = 1'b1;
    for (int k = 1; k <= S + 3; k++) push(k, 1'b0, 2'b00, 1'b1, "R3 short pulse");
    tick(S - 1);
    ovp_cmp = 1'b0;
    drain();

    // R5: temperature fault masked during soft-start
    softstart_act = 1'b1;
    tick(1);
    otp_cmp = 1'b1;
    push(trip_lat(S), 1'b0, 2'b00, 1'b1, "R5 masked at due");
    push(2 * S, 1'b0, 2'b00, 1'b1, "R5 masked later");
    drain();
    otp_cmp = 1'b0;
    tick(S + 2);
    softstart_act = 1'b0;
    push(2, 1'b0, 2'b00, 1'b1, "R5 no trip after");
    drain();

    // R6: temperature fault ignored with bias off
    supply_ok = 1'b0;
    push(1, 1'b0, 2'b00, 1'b0, "R6 bias off");
    drain();
    otp_cmp = 1'b1;
    push(trip_lat(S), 1'b0, 2'b00, 1'b0, "R6 masked at due");
    push(2 * S, 1'b0, 2'b00, 1'b0, "R6 masked later");
    drain();
    otp_cmp = 1'b0;
    tick(S + 2);
    supply_ok = 1'b1;
    tick(2);

    // R4: temperature trip
    otp_cmp = 1'b1;
    push(trip_lat(S) - 1, 1'b0, 2'b00, 1'b1, "R4 not early");
    push(trip_lat(S), 1'b1, 2'b10, 1'b1, "R4 temp trip");
    drain();
    // R7: later overvoltage keeps first cause
    ovp_cmp = 1'b1;
    push(2 * S, 1'b1, 2'b10, 1'b1, "R7 cause kept");
    drain();
    // R9: persists with comparators low
    ovp_cmp = 1'b0; otp_cmp = 1'b0;
    push(S + 3, 1'b1, 2'b10, 1'b1, "R9 persists");
    drain();
    latch_clr = 1'b1;
    push(1, 1'b0, 2'b00, 1'b1, "R9 cleared");
    tick(1);
    latch_clr = 1'b0;
    drain();

    // R2: overvoltage trip
    ovp_cmp = 1'b1;
    push(trip_lat(S) - 1, 1'b0, 2'b00, 1'b1, "R2 not early");
    push(trip_lat(S), 1'b1, 2'b01, 1'b1, "R2 over trip");
    drain();
    ovp_cmp = 1'b0;
    tick(S + 2);
    latch_clr = 1'b1;
    push(1, 1'b0, 2'b00, 1'b1, "R9 clear after R2");
    tick(1);
    latch_clr = 1'b0;
    drain();

    // R8: simultaneous faults
    ovp_cmp = 1'b1; otp_cmp = 1'b1;
    push(trip_lat(S), 1'b1, 2'b01, 1'b1, "R8 priority");
    drain();
    ovp_cmp = 1'b0; otp_cmp = 1'b0;
    tick(S + 2);
    latch_clr = 1'b1;
    push(1, 1'b0, 2'b00, 1'b1, "R9 clear after R8");
    drain();

    // R10: clear held blocks the trip, release lets it latch
    ovp_cmp = 1'b1;
    push(trip_lat(S), 1'b0, 2'b00, 1'b1, "R10 blocked at due");
    push(2 * S, 1'b0, 2'b00, 1'b1, "R10 blocked later");
    drain();
    latch_clr = 1'b0;
    push(1, 1'b1, 2'b01, 1'b1, "R10 trip on release");
    drain();
    ovp_cmp = 1'b0;
    tick(2);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule